// File: doc/BRIEF.md
# Mode-Switch Register with Countdown

This block keeps the processor's mode bits. Each mode bit opens one group of extended instructions. For every retiring instruction the decoder presents the group the instruction needs, the current privilege level, whether it is a mode-set instruction and whether it moves the program counter non-sequentially. In the same cycle the block answers allow or trap, and when it traps it gives a cause code. A mode-set instruction that is allowed writes the masked mode bits, and its effect starts with the next instruction.

A mode-set instruction may also load a small countdown tied to one mode bit. The block then turns that bit on for exactly the next N instructions that retire cleanly, and clears it again with no further instruction. A branch that retires while the countdown runs is trapped. Some bits are privileged, such as the data width select, and only supervisor code may write them. Other bits can be written from user code. Bits in the reserved region can never be set.

The exception logic can read the whole mode state at any time from the save ports. It can write the state back in one cycle through the restore ports, and the countdown then carries on from the value it had when it was saved.

Top module: `mswr_top`

## Requirements
- R1: After reset all mode bits are clear, the countdown is zero, and neither allow nor trap is raised while no instruction retires.
- R2: A retiring instruction with `ret_ext`=1 whose mode bit, bit `ret_group` of the mode, is clear traps in the same cycle with cause 0 (mode off).
- R3: An allowed mode-set replaces each bit selected by `mset_mask` with the matching bit of `mset_value`. The new bits govern the instruction that retires in the next cycle.
- R4: A mode-set from user level (`ret_priv`=0) that would write a privileged bit traps with cause 2. Bits 0 and 1 are the privileged bits, and a write means the bit is in the mask or is the countdown bit. The same write from supervisor level is allowed.
- R5: A mode-set that would set any bit in bits 12 to 15, the reserved region, traps with cause 3. Bits 12 to 15 are forced to zero when the state is restored.
- R6: A mode-set with `mset_count`=N, where N is 1 to 15, sets bit `mset_cd_idx` and keeps it set for exactly the next N instructions that retire without a trap. The bit is then cleared, and no instruction is needed to clear it.
- R7: An instruction that traps does not decrement the countdown.
- R8: A retiring instruction with `ret_nonseq`=1 traps with cause 1 while the countdown is non-zero. After the countdown reaches zero the same instruction is allowed.
- R9: The save ports always show the current mode bits, countdown and countdown bit index. Writing those values back through the restore port makes the countdown resume from the saved value.
- R10: When a restore and an allowed mode-set happen in the same cycle, only the restore takes effect.
- R11: A mode-set with `mset_count`=0 leaves the written bits set with no expiry. It also cancels any countdown that is running.
- R12: An instruction that traps leaves the mode bits and the countdown unchanged.
- R13: When several trap conditions hold together, the cause is chosen in this order: privilege (2), then reserved (3), then mode off (0), then branch in the countdown window (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_ext | input | 1 | The instruction belongs to an extension group |
| ret_group | input | 4 | Index of the mode bit that the group needs |
| ret_priv | input | 1 | 1 = supervisor level, 0 = user level |
| ret_nonseq | input | 1 | The instruction changes the program counter non-sequentially |
| ret_mset | input | 1 | The instruction is a mode-set |
| mset_mask | input | 16 | Mode bits that the mode-set writes |
| mset_value | input | 16 | New values for the masked bits |
| mset_count | input | 4 | Countdown load; 0 means persistent |
| mset_cd_idx | input | 4 | Mode bit that the countdown controls |
| rest_valid | input | 1 | Restore the saved state this cycle |
| rest_mode | input | 16 | Mode bits to restore |
| rest_count | input | 4 | Countdown to restore |
| rest_cd_idx | input | 4 | Countdown bit index to restore |
| ins_allow | output | 1 | The retiring instruction may execute |
| ins_trap | output | 1 | The retiring instruction raises an illegal-instruction trap |
| trap_cause | output | 2 | 0 mode off, 1 branch in window, 2 privilege, 3 reserved |
| save_mode | output | 16 | Current mode bits |
| save_count | output | 4 | Current countdown |
| save_cd_idx | output | 4 | Current countdown bit index |

## Verification
Some behaviour can be checked on every cycle, and the assertions do that. They check that an instruction needing a clear mode bit traps, and that a branch inside the window traps. They check that reserved bits never become set, that a trapped instruction freezes the state, that a count of one followed by a clean retire clears the controlled bit, and that a restore loads exactly the restored values. Other behaviour only shows over whole scenarios, and the bench's reference model covers it. This includes the exact window length after loads of various sizes, and the fact that a trapped instruction inside the window does not shorten it. It also includes the countdown resuming after a save and restore, the cause chosen when several conditions overlap, and the restore winning over a mode-set in the same cycle.

// File: rtl/mswr_pkg.sv
package mswr_pkg;

    typedef enum logic [1:0] {
        CAUSE_MODE_OFF   = 2'd0,
        CAUSE_BRANCH_WIN = 2'd1,
        CAUSE_PRIV       = 2'd2,
        CAUSE_RSVD       = 2'd3
    } trap_cause_e;

endpackage

// File: rtl/mswr_onehot.sv
module mswr_onehot #(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx,
    input  logic             en,
    output logic [W-1:0]     vec
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign vec[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/mswr_decide.sv
module mswr_decide
    import mswr_pkg::*;
#(
    parameter int              MODE_W    = 16,
    parameter int              CNT_W     = 4,
    parameter int              IDX_W     = 4,
    parameter logic [MODE_W-1:0] PRIV_MASK = 16'h0003,
    parameter logic [MODE_W-1:0] RSV_MASK  = 16'hF000
) (
    input  logic [MODE_W-1:0] mode_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic              ret_valid,
    input  logic              ret_ext,
    input  logic [IDX_W-1:0]  ret_group,
    input  logic              ret_priv,
    input  logic              ret_nonseq,
    input  logic              ret_mset,
    input  logic [MODE_W-1:0] mset_mask,
    input  logic [MODE_W-1:0] mset_value,
    input  logic [MODE_W-1:0] load_bit,
    output logic              trap,
    output logic              allow,
    output trap_cause_e       cause
);
    logic [MODE_W-1:0] touched;
    logic [MODE_W-1:0] raised;
    logic              priv_bad;
    logic              rsv_bad;
    logic              off_bad;
    logic              win_bad;

    always_comb begin
        touched  = mset_mask | load_bit;
        raised   = (mset_mask & mset_value) | load_bit;
        priv_bad = ret_mset && !ret_priv && ((touched & PRIV_MASK) != '0);
        rsv_bad  = ret_mset && ((raised & RSV_MASK) != '0);
        off_bad  = ret_ext && !mode_q[ret_group];
        win_bad  = ret_nonseq && (cnt_q != '0);

        cause = CAUSE_MODE_OFF;
        if (priv_bad)      cause = CAUSE_PRIV;
        else if (rsv_bad)  cause = CAUSE_RSVD;
        else if (off_bad)  cause = CAUSE_MODE_OFF;
        else if (win_bad)  cause = CAUSE_BRANCH_WIN;

        trap  = ret_valid && (priv_bad || rsv_bad || off_bad || win_bad);
        allow = ret_valid && !trap;
    end
endmodule

// File: rtl/mswr_next.sv
module mswr_next #(
    parameter int                MODE_W   = 16,
    parameter int                CNT_W    = 4,
    parameter int                IDX_W    = 4,
    parameter logic [MODE_W-1:0] RSV_MASK = 16'hF000
) (
    input  logic [MODE_W-1:0] mode_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [IDX_W-1:0]  cdi_q,
    input  logic              retire_ok,
    input  logic              ret_mset,
    input  logic [MODE_W-1:0] mset_mask,
    input  logic [MODE_W-1:0] mset_value,
    input  logic [CNT_W-1:0]  mset_count,
    input  logic [IDX_W-1:0]  mset_cd_idx,
    input  logic [MODE_W-1:0] load_bit,
    input  logic [MODE_W-1:0] expire_bit,
    input  logic              rest_valid,
    input  logic [MODE_W-1:0] rest_mode,
    input  logic [CNT_W-1:0]  rest_count,
    input  logic [IDX_W-1:0]  rest_cd_idx,
    output logic [MODE_W-1:0] mode_d,
    output logic [CNT_W-1:0]  cnt_d,
    output logic [IDX_W-1:0]  cdi_d
);
    always_comb begin
        mode_d = mode_q;
        cnt_d  = cnt_q;
        cdi_d  = cdi_q;
        if (rest_valid) begin
            mode_d = rest_mode & ~RSV_MASK;
            cnt_d  = rest_count;
            cdi_d  = rest_cd_idx;
        end else if (retire_ok && ret_mset) begin
            mode_d = (mode_q & ~mset_mask) | (mset_value & mset_mask) | load_bit;
            cnt_d  = mset_count;
            cdi_d  = mset_cd_idx;
        end else if (retire_ok && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
            if (cnt_q == CNT_W'(1)) begin
                mode_d = mode_q & ~expire_bit;
            end
        end
    end
endmodule

// File: rtl/mswr_top.sv
module mswr_top
    import mswr_pkg::*;
#(
    parameter int                MODE_W    = 16,
    parameter int                CNT_W     = 4,
    parameter logic [MODE_W-1:0] PRIV_MASK = 16'h0003,
    parameter logic [MODE_W-1:0] RSV_MASK  = 16'hF000,
    localparam int               IDX_W     = $clog2(MODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ret_valid,
    input  logic              ret_ext,
    input  logic [IDX_W-1:0]  ret_group,
    input  logic              ret_priv,
    input  logic              ret_nonseq,
    input  logic              ret_mset,
    input  logic [MODE_W-1:0] mset_mask,
    input  logic [MODE_W-1:0] mset_value,
    input  logic [CNT_W-1:0]  mset_count,
    input  logic [IDX_W-1:0]  mset_cd_idx,
    input  logic              rest_valid,
    input  logic [MODE_W-1:0] rest_mode,
    input  logic [CNT_W-1:0]  rest_count,
    input  logic [IDX_W-1:0]  rest_cd_idx,
    output logic              ins_allow,
    output logic              ins_trap,
    output logic [1:0]        trap_cause,
    output logic [MODE_W-1:0] save_mode,
    output logic [CNT_W-1:0]  save_count,
    output logic [IDX_W-1:0]  save_cd_idx
);
    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  cdi;
    } state_t;

    state_t            state_d;
    state_t            state_q;
    logic [MODE_W-1:0] load_bit;
    logic [MODE_W-1:0] expire_bit;
    logic [MODE_W-1:0] mode_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [IDX_W-1:0]  cdi_n;
    logic              trap_w;
    logic              allow_w;
    trap_cause_e       cause_w;

    mswr_onehot #(.W(MODE_W), .IDX_W(IDX_W)) u_load_sel (
        .idx (mset_cd_idx),
        .en  (mset_count != '0),
        .vec (load_bit)
    );

    mswr_onehot #(.W(MODE_W), .IDX_W(IDX_W)) u_expire_sel (
        .idx (state_q.cdi),
        .en  (1'b1),
        .vec (expire_bit)
    );

    mswr_decide #(
        .MODE_W(MODE_W), .CNT_W(CNT_W), .IDX_W(IDX_W),
        .PRIV_MASK(PRIV_MASK), .RSV_MASK(RSV_MASK)
    ) u_decide (
        .mode_q     (state_q.mode),
        .cnt_q      (state_q.cnt),
        .ret_valid  (ret_valid),
        .ret_ext    (ret_ext),
        .ret_group  (ret_group),
        .ret_priv   (ret_priv),
        .ret_nonseq (ret_nonseq),
        .ret_mset   (ret_mset),
        .mset_mask  (mset_mask),
        .mset_value (mset_value),
        .load_bit   (load_bit),
        .trap       (trap_w),
        .allow      (allow_w),
        .cause      (cause_w)
    );

    mswr_next #(
        .MODE_W(MODE_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .RSV_MASK(RSV_MASK)
    ) u_next (
        .mode_q      (state_q.mode),
        .cnt_q       (state_q.cnt),
        .cdi_q       (state_q.cdi),
        .retire_ok   (allow_w),
        .ret_mset    (ret_mset),
        .mset_mask   (mset_mask),
        .mset_value  (mset_value),
        .mset_count  (mset_count),
        .mset_cd_idx (mset_cd_idx),
        .load_bit    (load_bit),
        .expire_bit  (expire_bit),
        .rest_valid  (rest_valid),
        .rest_mode   (rest_mode),
        .rest_count  (rest_count),
        .rest_cd_idx (rest_cd_idx),
        .mode_d      (mode_n),
        .cnt_d       (cnt_n),
        .cdi_d       (cdi_n)
    );

    always_comb begin
        state_d      = state_q;
        state_d.mode = mode_n;
        state_d.cnt  = cnt_n;
        state_d.cdi  = cdi_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign ins_allow   = allow_w;
    assign ins_trap    = trap_w;
    assign trap_cause  = cause_w;
    assign save_mode   = state_q.mode;
    assign save_count  = state_q.cnt;
    assign save_cd_idx = state_q.cdi;
endmodule

// File: rtl/mswr_checker.sv
module mswr_checker #(
    parameter int                MODE_W   = 16,
    parameter int                CNT_W    = 4,
    parameter int                IDX_W    = 4,
    parameter logic [MODE_W-1:0] RSV_MASK = 16'hF000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ret_valid,
    input logic              ret_ext,
    input logic [IDX_W-1:0]  ret_group,
    input logic              ret_nonseq,
    input logic              ret_mset,
    input logic              rest_valid,
    input logic [CNT_W-1:0]  rest_count,
    input logic [IDX_W-1:0]  rest_cd_idx,
    input logic              ins_allow,
    input logic              ins_trap,
    input logic [MODE_W-1:0] save_mode,
    input logic [CNT_W-1:0]  save_count,
    input logic [IDX_W-1:0]  save_cd_idx
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |-> (!ins_allow && !ins_trap));

    assert_off_traps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_ext && !save_mode[ret_group]) |-> ins_trap);

    assert_no_reserved_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (save_mode & RSV_MASK) == '0);

    assert_expire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ins_allow && !ret_mset && !rest_valid && save_count == CNT_W'(1))
        |=> (save_count == '0 && !save_mode[$past(save_cd_idx)]));

    assert_branch_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_nonseq && save_count != '0) |-> ins_trap);

    assert_restore_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rest_valid |=> (save_count == $past(rest_count) && save_cd_idx == $past(rest_cd_idx)));

    assert_trap_freeze_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_trap && !rest_valid) |=> (save_mode == $past(save_mode) && save_count == $past(save_count)));
endmodule

bind mswr_top mswr_checker #(
    .MODE_W(MODE_W), .CNT_W(CNT_W), .IDX_W(IDX_W), .RSV_MASK(RSV_MASK)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ret_valid   (ret_valid),
    .ret_ext     (ret_ext),
    .ret_group   (ret_group),
    .ret_nonseq  (ret_nonseq),
    .ret_mset    (ret_mset),
    .rest_valid  (rest_valid),
    .rest_count  (rest_count),
    .rest_cd_idx (rest_cd_idx),
    .ins_allow   (ins_allow),
    .ins_trap    (ins_trap),
    .save_mode   (save_mode),
    .save_count  (save_count),
    .save_cd_idx (save_cd_idx)
);

// File: tb/mswr_top_bench.sv
`timescale 1ns/1ps
module mswr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ret_valid = 0, ret_ext = 0, ret_priv = 0, ret_nonseq = 0, ret_mset = 0;
    logic [3:0]  ret_group = 0;
    logic [15:0] mset_mask = 0, mset_value = 0;
    logic [3:0]  mset_count = 0, mset_cd_idx = 0;
    logic        rest_valid = 0;
    logic [15:0] rest_mode = 0;
    logic [3:0]  rest_count = 0, rest_cd_idx = 0;
    logic        ins_allow, ins_trap;
    logic [1:0]  trap_cause;
    logic [15:0] save_mode;
    logic [3:0]  save_count, save_cd_idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state
    logic [15:0] m_mode = 0;
    int          m_cnt = 0;
    int          m_cdi = 0;

    // snapshot for save/restore scenario
    logic [15:0] s_mode;
    logic [3:0]  s_cnt, s_cdi;

    always #4 clk = ~clk;

    mswr_top u_mswr_top (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .ret_ext(ret_ext), .ret_group(ret_group),
        .ret_priv(ret_priv), .ret_nonseq(ret_nonseq), .ret_mset(ret_mset),
        .mset_mask(mset_mask), .mset_value(mset_value),
        .mset_count(mset_count), .mset_cd_idx(mset_cd_idx),
        .rest_valid(rest_valid), .rest_mode(rest_mode),
        .rest_count(rest_count), .rest_cd_idx(rest_cd_idx),
        .ins_allow(ins_allow), .ins_trap(ins_trap), .trap_cause(trap_cause),
        .save_mode(save_mode), .save_count(save_count), .save_cd_idx(save_cd_idx)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        ret_valid = 0; ret_ext = 0; ret_priv = 0; ret_nonseq = 0; ret_mset = 0;
        ret_group = 0; mset_mask = 0; mset_value = 0; mset_count = 0; mset_cd_idx = 0;
        rest_valid = 0; rest_mode = 0; rest_count = 0; rest_cd_idx = 0;
    endtask

    // one clock: check decision, advance model, check state
    task automatic step(string tag);
        bit         e_trap;
        int         e_cause;
        logic [15:0] lb, touch, raise;
        #1;
        lb    = (mset_count != 0) ? (16'h1 << mset_cd_idx) : 16'h0;
        touch = mset_mask | lb;
        raise = (mset_mask & mset_value) | lb;
        e_trap = 1; e_cause = 0;
        if (ret_mset && !ret_priv && (touch & 16'h0003) != 0) e_cause = 2;
        else if (ret_mset && (raise & 16'hF000) != 0)         e_cause = 3;
        else if (ret_ext && !m_mode[ret_group])               e_cause = 0;
        else if (ret_nonseq && m_cnt != 0)                    e_cause = 1;
        else e_trap = 0;
        if (!ret_valid) e_trap = 0;
        check(tag, "trap", int'(ins_trap), int'(e_trap));
        check(tag, "allow", int'(ins_allow), int'(ret_valid && !e_trap));
        if (e_trap) check(tag, "cause", int'(trap_cause), e_cause);
        @(posedge clk);
        if (rest_valid) begin
            m_mode = rest_mode & 16'h0FFF;
            m_cnt  = rest_count;
            m_cdi  = rest_cd_idx;
        end else if (ret_valid && !e_trap) begin
            if (ret_mset) begin
                m_mode = (m_mode & ~mset_mask) | (mset_value & mset_mask) | lb;
                m_cnt  = mset_count;
                m_cdi  = mset_cd_idx;
            end else if (m_cnt != 0) begin
                m_cnt--;
                if (m_cnt == 0) m_mode[m_cdi] = 1'b0;
            end
        end
        #1;
        check(tag, "mode", int'(save_mode), int'(m_mode));
        check(tag, "count", int'(save_count), m_cnt);
        check(tag, "cd_idx", int'(save_cd_idx), m_cdi);
        @(negedge clk);
        idle();
    endtask

    task automatic ext_ins(string tag, int grp, bit nonseq);
        ret_valid = 1; ret_ext = 1; ret_group = 4'(grp); ret_nonseq = nonseq;
        step(tag);
    endtask

    task automatic plain_ins(string tag, bit nonseq);
        ret_valid = 1; ret_nonseq = nonseq;
        step(tag);
    endtask

    task automatic mset(string tag, bit priv, logic [15:0] mask, logic [15:0] val,
                        int cnt, int cdi);
        ret_valid = 1; ret_mset = 1; ret_priv = priv;
        mset_mask = mask; mset_value = val; mset_count = 4'(cnt); mset_cd_idx = 4'(cdi);
        step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset state, idle cycle
        step("R1");

        // R2: extension group with its bit clear
        ext_ins("R2", 5, 0);

        // R3 / R11: user sets bit 5 persistently
        mset("R3", 0, 16'h0020, 16'h0020, 0, 0);
        ext_ins("R3", 5, 0);
        for (int i = 0; i < 4; i++) ext_ins("R11", 5, 0);
        mset("R3", 0, 16'h0020, 16'h0000, 0, 0);
        ext_ins("R3", 5, 0);

        // R4 / R12: privileged bit from user traps and changes nothing
        mset("R4", 0, 16'h0001, 16'h0001, 0, 0);
        mset("R12", 0, 16'h0002, 16'h0002, 3, 4);
        mset("R4", 1, 16'h0001, 16'h0001, 0, 0);
        ext_ins("R4", 0, 0);

        // R5 / R13: reserved bit, and cause order
        mset("R5", 0, 16'h2000, 16'h2000, 0, 0);
        mset("R5", 1, 16'h0000, 16'h0000, 2, 14);
        mset("R13", 0, 16'h2001, 16'h2001, 0, 0);
        mset("R5", 1, 16'h8000, 16'h0000, 0, 0);

        // R6: window of 3 on bit 6
        mset("R6", 0, 16'h0000, 16'h0000, 3, 6);
        for (int i = 0; i < 3; i++) ext_ins("R6", 6, 0);
        ext_ins("R6", 6, 0);

        // R7: trapped instruction inside window does not consume
        mset("R7", 0, 16'h0000, 16'h0000, 2, 7);
        ext_ins("R7", 2, 0);
        ext_ins("R7", 7, 0);
        ext_ins("R7", 7, 0);
        ext_ins("R7", 7, 0);

        // R8 / R13: branch inside window, then after expiry
        mset("R8", 0, 16'h0000, 16'h0000, 2, 8);
        plain_ins("R8", 1);
        ext_ins("R13", 3, 1);
        plain_ins("R8", 0);
        plain_ins("R8", 0);
        plain_ins("R8", 1);

        // R11: zero load cancels a running window and keeps bits
        mset("R11", 0, 16'h0000, 16'h0000, 5, 10);
        mset("R11", 0, 16'h0000, 16'h0000, 0, 10);
        for (int i = 0; i < 6; i++) ext_ins("R11", 10, 0);

        // R9: save, disturb, restore, resume
        mset("R9", 0, 16'h0400, 16'h0000, 4, 9);
        ext_ins("R9", 9, 0);
        #1;
        s_mode = save_mode; s_cnt = save_count; s_cdi = save_cd_idx;
        check("R9", "saved_count", int'(s_cnt), 3);
        mset("R9", 0, 16'h0200, 16'h0000, 0, 0);
        ext_ins("R9", 9, 0);
        rest_valid = 1; rest_mode = s_mode; rest_count = s_cnt; rest_cd_idx = s_cdi;
        step("R9");
        for (int i = 0; i < 3; i++) ext_ins("R9", 9, 0);
        ext_ins("R9", 9, 0);

        // R10: restore and mode-set in the same cycle
        rest_valid = 1; rest_mode = 16'h0040; rest_count = 0; rest_cd_idx = 0;
        ret_valid = 1; ret_mset = 1; mset_mask = 16'h0080; mset_value = 16'h0080;
        step("R10");
        ext_ins("R10", 7, 0);
        ext_ins("R10", 6, 0);

        // R5: restored reserved bits forced clear
        rest_valid = 1; rest_mode = 16'hF020; rest_count = 0; rest_cd_idx = 0;
        step("R5");

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule